// File: doc/BRIEF.md
# Lane Execution Mask Controller

This block owns the lane-enable mask of a vector unit whose lanes run in lockstep under a scalar sequencer. Divergent branches and loops are expressed as a short series of mask commands. Each command takes one or two scalar operands: a per-lane compare result, a mask saved by an earlier command, or a break accumulator. The block updates the live mask and hands back a value for the sequencer to keep in a scalar register. No reconvergence stack exists in hardware. Every lane that a region disables is held in these returned values, and a later command hands them back as an operand.

A command is presented with `cmd_valid` for one clock. On that edge the block registers the new mask, the returned value and two flags. The skip flag tells the sequencer that an if or else body has no active lane and can be jumped over. The loop flag tells it that a loop back-edge still has live lanes and must be taken. Because the mask and result register together, a command issued on the very next clock already sees the updated mask.

Top module: `lane_mask_ctrl`

## Requirements
- R1: While `rst_n` is low, `lane_mask` is all ones, `rsp_result` is zero and `rsp_valid`, `rsp_skip` and `rsp_loop` are low.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `cmd_valid` is high. Commands issued on consecutive cycles each act on the mask left by the previous one. With `cmd_valid` low, the mask does not change.
- R3: Opcode 1 (branch-if) sets the mask to mask AND a and returns the lanes it switched off, old mask AND NOT a.
- R4: Opcode 2 (branch-if, single consumer) sets the mask to mask AND a and returns the whole old mask.
- R5: Opcode 3 (else) returns the old mask and sets the mask to (old OR a) XOR old, which enables only the saved lanes that were not active.
- R6: Opcode 4 (end-if) sets the mask to mask OR a and returns the new mask.
- R7: Opcode 5 (break) returns mask OR a and leaves the mask unchanged.
- R8: Opcodes 6 and 7 (conditional break forms) return a OR b and leave the mask unchanged.
- R9: Opcode 8 (loop back-edge) sets the mask to mask AND NOT a and returns the new mask. `rsp_loop` is high exactly when that new mask is nonzero.
- R10: `rsp_skip` is high after opcodes 1, 2 and 3 exactly when the new mask is zero. It is low after every other opcode.
- R11: Opcode 9 (load) sets the mask to a and returns a.
- R12: Opcodes 0 and 10 to 15 leave the mask unchanged, return zero and keep both flags low.
- R13: A properly nested if/else/end-if sequence, or a loop whose broken lanes are merged back afterwards, leaves the mask exactly as it was before the construct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_a | input | 64 | First operand (condition, saved mask or break mask) |
| cmd_b | input | 64 | Second operand (conditional break forms only) |
| lane_mask | output | 64 | Live lane-enable mask, one bit per lane |
| rsp_valid | output | 1 | Response registered for the previous cycle's command |
| rsp_result | output | 64 | Value to be saved into a scalar register |
| rsp_skip | output | 1 | Body of the if/else just entered has no active lane |
| rsp_loop | output | 1 | Loop back-edge must be taken |

## Verification
The assertions assume that `cmd_op`, `cmd_a` and `cmd_b` hold known values whenever `cmd_valid` is high, and that no command is issued while reset is asserted. The subset and disjointness properties on if, else and loop rely on the operands being arbitrary masks. Nothing further is assumed, so the sequencer may pass any saved value. The stimulus changes every input on the falling edge of the clock and keeps `cmd_valid` low throughout reset. Its operand values all come from earlier responses or from fixed constants, so no unknown bit ever reaches the block.

// File: rtl/lmc_pkg.sv
`timescale 1ns/1ps
package lmc_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NONE      = 4'd0,
    OP_IF        = 4'd1,
    OP_IF_SIMPLE = 4'd2,
    OP_ELSE      = 4'd3,
    OP_ENDIF     = 4'd4,
    OP_BREAK     = 4'd5,
    OP_IF_BRK    = 4'd6,
    OP_ELSE_BRK  = 4'd7,
    OP_LOOP      = 4'd8,
    OP_LOAD      = 4'd9
  } lmc_op_e;

endpackage

// File: rtl/lmc_eval.sv
`timescale 1ns/1ps
module lmc_eval
  import lmc_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             valid,
  input  logic [OPW-1:0]   op,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] opnd_a,
  input  logic [LANES-1:0] opnd_b,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] nxt_result,
  output logic             skip_eligible,
  output logic             loop_op
);

  // Lanes that stay active once the condition is applied.
  function automatic logic [LANES-1:0] f_narrow(input logic [LANES-1:0] m,
                                                input logic [LANES-1:0] c);
    return m & c;
  endfunction

  // Lanes that were active but were switched off by the narrowing.
  function automatic logic [LANES-1:0] f_dropped(input logic [LANES-1:0] m_old,
                                                 input logic [LANES-1:0] m_new);
    return m_old ^ m_new;
  endfunction

  // Else side: merge in the saved lanes, then remove the ones already run.
  function automatic logic [LANES-1:0] f_flip(input logic [LANES-1:0] m,
                                              input logic [LANES-1:0] s);
    logic [LANES-1:0] merged;
    merged = m | s;
    return merged ^ m;
  endfunction

  function automatic logic [LANES-1:0] f_merge(input logic [LANES-1:0] m,
                                               input logic [LANES-1:0] s);
    return m | s;
  endfunction

  function automatic logic [LANES-1:0] f_prune(input logic [LANES-1:0] m,
                                               input logic [LANES-1:0] brk);
    return m & ~brk;
  endfunction

  logic [LANES-1:0] narrowed;
  assign narrowed = f_narrow(cur_mask, opnd_a);

  always_comb begin
    nxt_mask      = cur_mask;
    nxt_result    = '0;
    skip_eligible = 1'b0;
    loop_op       = 1'b0;
    if (valid) begin
      case (op)
        OP_IF: begin
          nxt_mask      = narrowed;
          nxt_result    = f_dropped(cur_mask, narrowed);
          skip_eligible = 1'b1;
        end
        OP_IF_SIMPLE: begin
          nxt_mask      = narrowed;
          nxt_result    = cur_mask;
          skip_eligible = 1'b1;
        end
        OP_ELSE: begin
          nxt_mask      = f_flip(cur_mask, opnd_a);
          nxt_result    = cur_mask;
          skip_eligible = 1'b1;
        end
        OP_ENDIF: begin
          nxt_mask   = f_merge(cur_mask, opnd_a);
          nxt_result = f_merge(cur_mask, opnd_a);
        end
        OP_BREAK: begin
          nxt_result = f_merge(cur_mask, opnd_a);
        end
        OP_IF_BRK, OP_ELSE_BRK: begin
          nxt_result = opnd_a | opnd_b;
        end
        OP_LOOP: begin
          nxt_mask   = f_prune(cur_mask, opnd_a);
          nxt_result = f_prune(cur_mask, opnd_a);
          loop_op    = 1'b1;
        end
        OP_LOAD: begin
          nxt_mask   = opnd_a;
          nxt_result = opnd_a;
        end
        default: begin
          nxt_mask   = cur_mask;
          nxt_result = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lmc_zero_det.sv
`timescale 1ns/1ps
module lmc_zero_det #(
  parameter int W     = 64,
  parameter int SLICE = 16
) (
  input  logic [W-1:0] vec,
  output logic         all_zero
);

  localparam int NSL  = (W + SLICE - 1) / SLICE;
  localparam int PADW = NSL * SLICE;

  logic [PADW-1:0] padded;
  logic [NSL-1:0]  slice_any;

  assign padded = PADW'(vec);

  for (genvar gi = 0; gi < NSL; gi++) begin : g_slice
    assign slice_any[gi] = |padded[gi*SLICE +: SLICE];
  end

  assign all_zero = ~|slice_any;

endmodule

// File: rtl/lmc_regs.sv
`timescale 1ns/1ps
module lmc_regs #(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] nxt_mask,
  input  logic [LANES-1:0] nxt_result,
  input  logic             skip_in,
  input  logic             loop_in,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] result_q,
  output logic             valid_q,
  output logic             skip_q,
  output logic             loop_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      result_q <= '0;
    end else if (load) begin
      mask_q   <= nxt_mask;
      result_q <= nxt_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      skip_q  <= 1'b0;
      loop_q  <= 1'b0;
    end else begin
      valid_q <= load;
      skip_q  <= load & skip_in;
      loop_q  <= load & loop_in;
    end
  end

endmodule

// File: rtl/lane_mask_ctrl.sv
`timescale 1ns/1ps
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ZSLICE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [OPW-1:0]   cmd_op,
  input  logic [LANES-1:0] cmd_a,
  input  logic [LANES-1:0] cmd_b,
  output logic [LANES-1:0] lane_mask,
  output logic             rsp_valid,
  output logic [LANES-1:0] rsp_result,
  output logic             rsp_skip,
  output logic             rsp_loop
);

  logic [LANES-1:0] ev_nxt_mask;
  logic [LANES-1:0] ev_nxt_result;
  logic             ev_skip_eligible;
  logic             ev_loop_op;
  logic             ev_new_zero;
  logic             ev_skip;
  logic             ev_loop;

  lmc_eval #(.LANES(LANES)) u_eval (
    .valid         (cmd_valid),
    .op            (cmd_op),
    .cur_mask      (lane_mask),
    .opnd_a        (cmd_a),
    .opnd_b        (cmd_b),
    .nxt_mask      (ev_nxt_mask),
    .nxt_result    (ev_nxt_result),
    .skip_eligible (ev_skip_eligible),
    .loop_op       (ev_loop_op)
  );

  lmc_zero_det #(.W(LANES), .SLICE(ZSLICE)) u_zero (
    .vec      (ev_nxt_mask),
    .all_zero (ev_new_zero)
  );

  assign ev_skip = ev_skip_eligible & ev_new_zero;
  assign ev_loop = ev_loop_op & ~ev_new_zero;

  lmc_regs #(.LANES(LANES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_valid),
    .nxt_mask   (ev_nxt_mask),
    .nxt_result (ev_nxt_result),
    .skip_in    (ev_skip),
    .loop_in    (ev_loop),
    .mask_q     (lane_mask),
    .result_q   (rsp_result),
    .valid_q    (rsp_valid),
    .skip_q     (rsp_skip),
    .loop_q     (rsp_loop)
  );

endmodule

// File: rtl/lane_mask_ctrl_chk.sv
`timescale 1ns/1ps
module lane_mask_ctrl_chk
  import lmc_pkg::*;
#(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [OPW-1:0]   cmd_op,
  input logic [LANES-1:0] cmd_a,
  input logic [LANES-1:0] lane_mask,
  input logic             rsp_valid,
  input logic [LANES-1:0] rsp_result,
  input logic             rsp_skip,
  input logic             rsp_loop
);

  p_reset_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lane_mask == '1 && !rsp_valid));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!rsp_valid && $stable(lane_mask)));

  p_if_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_IF) |=>
      ((lane_mask & ~$past(lane_mask)) == '0 && (lane_mask & rsp_result) == '0));

  p_else_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ELSE) |=> ((lane_mask & rsp_result) == '0));

  p_endif_superset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ENDIF) |=>
      ((lane_mask & $past(lane_mask)) == $past(lane_mask)));

  p_break_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_BREAK || cmd_op == OP_IF_BRK || cmd_op == OP_ELSE_BRK))
      |=> $stable(lane_mask));

  p_loop_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LOOP) |=> ((lane_mask & $past(cmd_a)) == '0));

  p_loop_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_loop |-> (rsp_valid && lane_mask != '0));

  p_skip_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_skip |-> (rsp_valid && lane_mask == '0));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_skip, rsp_loop}) <= 1);

endmodule

bind lane_mask_ctrl lane_mask_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_a      (cmd_a),
  .lane_mask  (lane_mask),
  .rsp_valid  (rsp_valid),
  .rsp_result (rsp_result),
  .rsp_skip   (rsp_skip),
  .rsp_loop   (rsp_loop)
);

// File: tb/lane_mask_ctrl_test.sv
`timescale 1ns/1ps
module lane_mask_ctrl_test;
  import lmc_pkg::*;

  localparam int L = 64;

  typedef struct packed {
    logic [3:0]   op;
    logic [L-1:0] a;
    logic [L-1:0] b;
    logic [L-1:0] mask;
    logic [L-1:0] res;
    logic         skip;
    logic         loop;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd9, 64'hFF,   64'h0,  64'hFF,   64'hFF,   1'b0, 1'b0},
    '{4'd1, 64'h0F,   64'h0,  64'h0F,   64'hF0,   1'b0, 1'b0},
    '{4'd3, 64'hF0,   64'h0,  64'hF0,   64'h0F,   1'b0, 1'b0},
    '{4'd4, 64'h0F,   64'h0,  64'hFF,   64'hFF,   1'b0, 1'b0},
    '{4'd5, 64'h100,  64'h0,  64'hFF,   64'h1FF,  1'b0, 1'b0},
    '{4'd6, 64'h3,    64'h30, 64'hFF,   64'h33,   1'b0, 1'b0},
    '{4'd8, 64'h0F,   64'h0,  64'hF0,   64'hF0,   1'b0, 1'b1},
    '{4'd8, 64'hF0,   64'h0,  64'h0,    64'h0,    1'b0, 1'b0},
    '{4'd9, {L{1'b1}}, 64'h0, {L{1'b1}}, {L{1'b1}}, 1'b0, 1'b0},
    '{4'd2, 64'h0,    64'h0,  64'h0,    {L{1'b1}}, 1'b1, 1'b0},
    '{4'd4, {L{1'b1}}, 64'h0, {L{1'b1}}, {L{1'b1}}, 1'b0, 1'b0},
    '{4'd12, 64'h5,   64'h9,  {L{1'b1}}, 64'h0,   1'b0, 1'b0},
    '{4'd7, 64'h1,    64'h2,  {L{1'b1}}, 64'h3,   1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [3:0]   cmd_op;
  logic [L-1:0] cmd_a;
  logic [L-1:0] cmd_b;
  logic [L-1:0] lane_mask;
  logic         rsp_valid;
  logic [L-1:0] rsp_result;
  logic         rsp_skip;
  logic         rsp_loop;

  int checks = 0;
  int errors = 0;
  logic [L-1:0] m_mask;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_mask_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .lane_mask(lane_mask), .rsp_valid(rsp_valid),
    .rsp_result(rsp_result), .rsp_skip(rsp_skip), .rsp_loop(rsp_loop)
  );

  task automatic chk(input string tag, input string what,
                     input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R11";
      default: return "R12";
    endcase
  endfunction

  // Independent reference: each opcode restated in its own terms.
  task automatic model(input logic [3:0] op, input logic [L-1:0] a, input logic [L-1:0] b,
                       output logic [L-1:0] e_mask, output logic [L-1:0] e_res,
                       output logic e_skip, output logic e_loop);
    e_mask = m_mask; e_res = '0; e_skip = 1'b0; e_loop = 1'b0;
    case (op)
      4'd1: begin e_mask = a & m_mask; e_res = m_mask & ~a; e_skip = (e_mask == '0); end
      4'd2: begin e_mask = a & m_mask; e_res = m_mask;      e_skip = (e_mask == '0); end
      4'd3: begin e_mask = a & ~m_mask; e_res = m_mask;     e_skip = (e_mask == '0); end
      4'd4: begin e_mask = a | m_mask; e_res = e_mask; end
      4'd5: e_res = a | m_mask;
      4'd6, 4'd7: e_res = b | a;
      4'd8: begin e_mask = ~a & m_mask; e_res = e_mask; e_loop = (e_mask != '0); end
      4'd9: begin e_mask = a; e_res = a; end
      default: ;
    endcase
    m_mask = e_mask;
  endtask

  task automatic issue(input logic [3:0] op, input logic [L-1:0] a, input logic [L-1:0] b);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_a     = a;
    cmd_b     = b;
    @(negedge clk);
  endtask

  task automatic run(input logic [3:0] op, input logic [L-1:0] a, input logic [L-1:0] b,
                     output logic [L-1:0] res);
    logic [L-1:0] e_mask, e_res;
    logic e_skip, e_loop;
    string t;
    t = tag_of(op);
    model(op, a, b, e_mask, e_res, e_skip, e_loop);
    issue(op, a, b);
    chk("R2", "rsp_valid", L'(rsp_valid), L'(1'b1));
    chk(t, "lane_mask", lane_mask, e_mask);
    chk(t, "rsp_result", rsp_result, e_res);
    chk("R10", "rsp_skip", L'(rsp_skip), L'(e_skip));
    chk("R9", "rsp_loop", L'(rsp_loop), L'(e_loop));
    res = rsp_result;
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [L-1:0] r, s1, s2, s3, brk, init;
    logic [L-1:0] conds [4];
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = '0;
    cmd_a = '0;
    cmd_b = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset lane_mask", lane_mask, {L{1'b1}});
    chk("R1", "reset rsp_result", rsp_result, '0);
    chk("R1", "reset flags", L'({rsp_valid, rsp_skip, rsp_loop}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mask after release", lane_mask, {L{1'b1}});

    // Table of hand-computed vectors, issued back to back.
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].a, TBL[i].b);
      chk("R2", "rsp_valid", L'(rsp_valid), L'(1'b1));
      chk(tag_of(TBL[i].op), "table mask", lane_mask, TBL[i].mask);
      chk(tag_of(TBL[i].op), "table result", rsp_result, TBL[i].res);
      chk("R10", "table skip", L'(rsp_skip), L'(TBL[i].skip));
      chk("R9", "table loop", L'(rsp_loop), L'(TBL[i].loop));
    end
    m_mask = TBL[NV-1].mask;

    // Idle cycle: no response, mask held.
    idle();
    chk("R2", "idle rsp_valid", L'(rsp_valid), '0);
    chk("R2", "idle mask", lane_mask, m_mask);

    // Else where every lane already ran the if side: skip.
    run(4'd9, 64'hF, '0, r);
    run(4'd1, 64'hF, '0, s1);
    run(4'd3, s1, '0, r);
    chk("R10", "else empty skip", L'(rsp_skip), L'(1'b1));
    run(4'd4, r, '0, r);

    // Nested if/else/end-if restores the mask (R13).
    init = 64'hDEAD_BEEF_0123_4567;
    run(4'd9, init, '0, r);
    run(4'd1, 64'hFFFF_0000_FFFF_0000, '0, s1);
    run(4'd1, 64'h0F0F_0F0F_0F0F_0F0F, '0, s2);
    run(4'd3, s2, '0, s2);
    run(4'd4, s2, '0, r);
    run(4'd3, s1, '0, s1);
    run(4'd2, 64'h3333_3333_3333_3333, '0, s3);
    run(4'd4, s3, '0, r);
    run(4'd4, s1, '0, r);
    chk("R13", "nested restore", lane_mask, init);
    idle();

    // Loop with per-lane breaks, then merge broken lanes back (R13).
    conds[0] = 64'h0000_0000_0000_FFFF;
    conds[1] = 64'h00FF_00FF_00FF_00FF;
    conds[2] = 64'h8000_0001_0000_0000;
    conds[3] = {L{1'b1}};
    init = 64'hFEDC_BA98_7654_3210;
    run(4'd9, init, '0, r);
    brk = '0;
    for (int it = 0; it < 4; it++) begin
      run(4'd1, conds[it], '0, s1);
      run(4'd5, brk, '0, brk);
      run(4'd4, s1, '0, r);
      run(4'd8, brk, '0, r);
    end
    chk("R9", "loop exits empty", lane_mask, '0);
    run(4'd4, brk, '0, r);
    chk("R13", "loop restore", lane_mask, init);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule